// File: doc/BRIEF.md
# Serial Controller Host Bus Register Front End

This block is the processor-facing side of a PC-style serial controller. It takes an 8-bit byte-wide bus with a 3-bit register offset, three chip selects of mixed polarity, an optional address strobe, and read and write strobes that each come in an active-high and an active-low form. From these it decides whether the device is addressed, which register is meant, and whether the access reads or writes.

The block holds the line control register, the modem control register, the two bytes of the baud divisor, and simple placeholder registers for the data and interrupt-enable slots. It drives two active-low general-purpose outputs from the modem control register and drives a driver-disable output during reads. It also produces the 16x baud tick from the system clock and the divisor. Bit 7 of the line control register switches offsets 0 and 1 over to the divisor bytes. A master reset input clears everything.

Top module: `uart_host_regs`

## Requirements
- R1: The device is addressed only when selHiA=1, selHiB=1 and selLoN=0. Otherwise dataOut is 0, drvDisableN is 1 and writes change no register.
- R2: A read is active when rdHi=1 or rdLoN=0. A write is active when wrHi=1 or wrLoN=0. Either form of each strobe has the same effect.
- R3: While addrStrobeN=0, the address and chip selects pass straight through. While addrStrobeN=1, the block uses the address and selects sampled at the last clock edge at which addrStrobeN was 0.
- R4: With line control bit 7 clear, offset 0 is the data register and offset 1 is interrupt enable. With bit 7 set, offset 0 is the divisor low byte and offset 1 is the divisor high byte. Offset 3 is line control and offset 4 is modem control in both cases. A read returns the byte last written to the register it selects.
- R5: Offsets 2, 5, 6 and 7 read as 0, and writes to them leave every other register unchanged.
- R6: drvDisableN is 0 exactly while an addressed read is active.
- R7: out1N is the inverse of modem control bit 2 and out2N is the inverse of bit 3. Both follow a write on the clock edge that stores it.
- R8: With a divisor D of 1 or more, baudClk16x is high for exactly one clock cycle in every D. When D=1 it stays high.
- R9: A divisor of 0 holds baudClk16x low.
- R10: Master reset clears every register to 0. After reset, reads return 0, out1N and out2N are 1, and the baud output is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstMaster | input | 1 | Master reset, active high, asynchronous |
| addrStrobeN | input | 1 | Address strobe, active low; tie to 0 for pass-through |
| selHiA | input | 1 | Chip select, active high |
| selHiB | input | 1 | Chip select, active high |
| selLoN | input | 1 | Chip select, active low |
| addr | input | 3 | Register offset |
| rdHi | input | 1 | Read strobe, active high |
| rdLoN | input | 1 | Read strobe, active low |
| wrHi | input | 1 | Write strobe, active high |
| wrLoN | input | 1 | Write strobe, active low |
| dataIn | input | 8 | Write data byte |
| dataOut | output | 8 | Read data byte, 0 when not read |
| drvDisableN | output | 1 | Low during an addressed read |
| out1N | output | 1 | General-purpose output, active low |
| out2N | output | 1 | General-purpose output, active low |
| baudClk16x | output | 1 | 16x baud tick |

## Verification
A wrong bank bit would show up on the very next read of offset 0 or 1, which would then return a data byte where a divisor byte was expected, or the other way round. It would also change the baud tick rate within D cycles. A corrupted modem control bit shows on out1N or out2N on the clock after the write. A stale latched address shows on the first read made with the strobe high. A wrong divisor or counter shows as a wrong number of ticks within one window of a few divisor periods.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

  typedef enum logic [2:0] {
    RS_NONE, RS_DATA, RS_IER, RS_LCR, RS_MCR, RS_DLL, RS_DLM
  } rdSel_e;

  typedef struct packed {
    logic wrData;
    logic wrIer;
    logic wrLcr;
    logic wrMcr;
    logic wrDll;
    logic wrDlm;
  } regStrobes_t;

  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_IER  = 1;
  localparam int unsigned OFS_LCR  = 3;
  localparam int unsigned OFS_MCR  = 4;

endpackage

// File: rtl/uart_bus_ctrl.sv
module uart_bus_ctrl
  import uart_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstMaster,
  input  logic              addrStrobeN,
  input  logic              selHiA,
  input  logic              selHiB,
  input  logic              selLoN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdHi,
  input  logic              rdLoN,
  input  logic              wrHi,
  input  logic              wrLoN,
  input  logic              dlab,
  output regStrobes_t       strb,
  output rdSel_e            rdSel,
  output logic              drvDisableN
);

  logic [ADDR_W-1:0] latAddr;
  logic [2:0]        latSel;
  logic [ADDR_W-1:0] effAddr;
  logic [2:0]        effSel;
  logic              chipSel, rdAct, wrAct;

  // Address and selects are captured each clock edge while the strobe is low.
  // Once the strobe rises, the last captured values are held.
  always_ff @(posedge clk or posedge rstMaster) begin
    if (rstMaster) begin
      latAddr <= '0;
      latSel  <= 3'b001;
    end else if (!addrStrobeN) begin
      latAddr <= addr;
      latSel  <= {selHiA, selHiB, selLoN};
    end
  end

  assign effAddr = addrStrobeN ? latAddr : addr;
  assign effSel  = addrStrobeN ? latSel : {selHiA, selHiB, selLoN};
  assign chipSel = effSel[2] & effSel[1] & ~effSel[0];
  assign rdAct   = chipSel & (rdHi | ~rdLoN);
  assign wrAct   = chipSel & (wrHi | ~wrLoN);
  assign drvDisableN = ~rdAct;

  always_comb begin
    strb  = '0;
    rdSel = RS_NONE;
    case (int'(effAddr))
      OFS_DATA: begin
        if (dlab) begin strb.wrDll = wrAct; rdSel = RS_DLL; end
        else      begin strb.wrData = wrAct; rdSel = RS_DATA; end
      end
      OFS_IER: begin
        if (dlab) begin strb.wrDlm = wrAct; rdSel = RS_DLM; end
        else      begin strb.wrIer = wrAct; rdSel = RS_IER; end
      end
      OFS_LCR: begin strb.wrLcr = wrAct; rdSel = RS_LCR; end
      OFS_MCR: begin strb.wrMcr = wrAct; rdSel = RS_MCR; end
      default: ;
    endcase
    if (!rdAct) rdSel = RS_NONE;
  end

  // R4: a single access never strobes two registers
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rstMaster)
    $onehot0(strb));

  // R1: no register strobe while the device is not addressed
  a_r1_no_strobe_unselected: assert property (@(posedge clk) disable iff (rstMaster)
    drvDisableN && !(wrHi || !wrLoN) |-> strb == '0);

endmodule

// File: rtl/uart_reg_datapath.sv
module uart_reg_datapath
  import uart_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstMaster,
  input  regStrobes_t       strb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              dlab,
  output logic [DIV_W-1:0]  divisor,
  output logic              out1N,
  output logic              out2N
);

  logic [DATA_W-1:0] dataReg, ierReg, lcrReg, mcrReg, dllReg, dlmReg;

  always_ff @(posedge clk or posedge rstMaster) begin
    if (rstMaster) begin
      dataReg <= '0;
      ierReg  <= '0;
      lcrReg  <= '0;
      mcrReg  <= '0;
      dllReg  <= '0;
      dlmReg  <= '0;
    end else begin
      if (strb.wrData) dataReg <= busWrData;
      if (strb.wrIer)  ierReg  <= busWrData;
      if (strb.wrLcr)  lcrReg  <= busWrData;
      if (strb.wrMcr)  mcrReg  <= busWrData;
      if (strb.wrDll)  dllReg  <= busWrData;
      if (strb.wrDlm)  dlmReg  <= busWrData;
    end
  end

  assign dlab    = lcrReg[DATA_W-1];
  assign divisor = {dlmReg, dllReg};
  assign out1N   = ~mcrReg[2];
  assign out2N   = ~mcrReg[3];

  always_comb begin
    case (rdSel)
      RS_DATA: rdData = dataReg;
      RS_IER:  rdData = ierReg;
      RS_LCR:  rdData = lcrReg;
      RS_MCR:  rdData = mcrReg;
      RS_DLL:  rdData = dllReg;
      RS_DLM:  rdData = dlmReg;
      default: rdData = '0;
    endcase
  end

  // R7: pins follow the stored control bits one edge after the write
  a_r7_out_pins: assert property (@(posedge clk) disable iff (rstMaster)
    strb.wrMcr |=> (out1N == !$past(busWrData[2])) && (out2N == !$past(busWrData[3])));

  // R4: the data slot is never written while the divisor bank is open
  a_r4_bank: assert property (@(posedge clk) disable iff (rstMaster)
    strb.wrData |-> !dlab);

  // R5: the divisor changes only through its own strobes
  a_r5_div_hold: assert property (@(posedge clk) disable iff (rstMaster)
    !strb.wrDll && !strb.wrDlm |=> $stable(divisor));

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstMaster,
  input  logic [DIV_W-1:0] divisor,
  output logic             baudTick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or posedge rstMaster) begin
    if (rstMaster) begin
      cnt      <= '0;
      baudTick <= 1'b0;
    end else if (divisor == '0) begin
      cnt      <= '0;
      baudTick <= 1'b0;
    end else if (cnt >= divisor - DIV_W'(1)) begin
      cnt      <= '0;
      baudTick <= 1'b1;
    end else begin
      cnt      <= cnt + DIV_W'(1);
      baudTick <= 1'b0;
    end
  end

  // R9: a zero divisor stops the tick
  a_r9_zero_stop: assert property (@(posedge clk) disable iff (rstMaster)
    divisor == '0 |=> !baudTick);

  // R8: the counter never passes the divisor it runs against
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rstMaster)
    divisor != '0 |=> cnt < $past(divisor));

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstMaster,
  input  logic              addrStrobeN,
  input  logic              selHiA,
  input  logic              selHiB,
  input  logic              selLoN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdHi,
  input  logic              rdLoN,
  input  logic              wrHi,
  input  logic              wrLoN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              drvDisableN,
  output logic              out1N,
  output logic              out2N,
  output logic              baudClk16x
);

  regStrobes_t      strb;
  rdSel_e           rdSel;
  logic             dlab;
  logic [DIV_W-1:0] divisor;

  uart_bus_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstMaster(rstMaster), .addrStrobeN(addrStrobeN),
    .selHiA(selHiA), .selHiB(selHiB), .selLoN(selLoN), .addr(addr),
    .rdHi(rdHi), .rdLoN(rdLoN), .wrHi(wrHi), .wrLoN(wrLoN),
    .dlab(dlab), .strb(strb), .rdSel(rdSel), .drvDisableN(drvDisableN)
  );

  uart_reg_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstMaster(rstMaster), .strb(strb), .rdSel(rdSel),
    .busWrData(dataIn), .rdData(dataOut), .dlab(dlab), .divisor(divisor),
    .out1N(out1N), .out2N(out2N)
  );

  uart_baud_gen #(.DIV_W(DIV_W)) uBaud (
    .clk(clk), .rstMaster(rstMaster), .divisor(divisor), .baudTick(baudClk16x)
  );

  // R6: driver disable is high whenever the read data bus is idle-zero by deselect
  a_r6_drv_idle: assert property (@(posedge clk) disable iff (rstMaster)
    !(rdHi || !rdLoN) |-> drvDisableN && dataOut == '0);

endmodule

// File: tb/tb_uart_host_regs.sv
module tb_uart_host_regs;

  logic       clk = 1'b0;
  logic       rstMaster = 1'b1;
  logic       addrStrobeN = 1'b0;
  logic       selHiA = 1'b1, selHiB = 1'b1, selLoN = 1'b0;
  logic [2:0] addr = '0;
  logic       rdHi = 1'b0, rdLoN = 1'b1, wrHi = 1'b0, wrLoN = 1'b1;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       drvDisableN, out1N, out2N, baudClk16x;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_host_regs dut (
    .clk(clk), .rstMaster(rstMaster), .addrStrobeN(addrStrobeN),
    .selHiA(selHiA), .selHiB(selHiB), .selLoN(selLoN), .addr(addr),
    .rdHi(rdHi), .rdLoN(rdLoN), .wrHi(wrHi), .wrLoN(wrLoN),
    .dataIn(dataIn), .dataOut(dataOut), .drvDisableN(drvDisableN),
    .out1N(out1N), .out2N(out2N), .baudClk16x(baudClk16x)
  );

  // {isWrite, offset, writeData, expectedRead}
  localparam int NVEC = 27;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 3'd3, 8'h03, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h03},
    {1'b1, 3'd0, 8'h5A, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h5A},
    {1'b1, 3'd1, 8'h0F, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h0F},
    {1'b1, 3'd4, 8'h1C, 8'h00}, {1'b0, 3'd4, 8'h00, 8'h1C},
    {1'b1, 3'd3, 8'h83, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h00}, {1'b1, 3'd0, 8'h04, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h04},
    {1'b0, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h83},
    {1'b1, 3'd3, 8'h03, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h5A},
    {1'b0, 3'd1, 8'h00, 8'h0F}, {1'b1, 3'd2, 8'hFF, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h00}, {1'b1, 3'd7, 8'hAA, 8'h00},
    {1'b0, 3'd7, 8'h00, 8'h00}, {1'b0, 3'd5, 8'h00, 8'h00},
    {1'b0, 3'd6, 8'h00, 8'h00}, {1'b0, 3'd4, 8'h00, 8'h1C},
    {1'b0, 3'd3, 8'h00, 8'h03}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d, input bit highForm);
    @(negedge clk);
    addr = a; dataIn = d;
    if (highForm) wrHi = 1'b1; else wrLoN = 1'b0;
    @(negedge clk);
    wrHi = 1'b0; wrLoN = 1'b1;
  endtask

  task automatic busRead(input logic [2:0] a, input bit highForm,
                         output logic [7:0] v, output logic dd);
    @(negedge clk);
    addr = a;
    if (highForm) rdHi = 1'b1; else rdLoN = 1'b0;
    #1;
    v = dataOut; dd = drvDisableN;
    rdHi = 1'b0; rdLoN = 1'b1;
  endtask

  task automatic countTicks(input int settle, input int window, output int n);
    n = 0;
    repeat (settle) @(negedge clk);
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (baudClk16x) n++;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic dd;
    int n;

    repeat (3) @(negedge clk);
    // R10: reset state at the pins
    chk("R10 out1N at reset", out1N, 1);
    chk("R10 out2N at reset", out2N, 1);
    chk("R10 baud idle at reset", baudClk16x, 0);
    chk("R6 drvDisableN idle", drvDisableN, 1);
    rstMaster = 1'b0;

    // R4 R5 R2: register map walk, strobe form alternates per entry
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19]) busWrite(VEC[i][18:16], VEC[i][15:8], (i % 2) == 0);
      else begin
        busRead(VEC[i][18:16], (i % 2) == 0, v, dd);
        if (VEC[i][18:16] inside {3'd2, 3'd5, 3'd6, 3'd7})
          chk("R5 unimplemented offset read", v, VEC[i][7:0]);
        else
          chk("R4 R2 register read", v, VEC[i][7:0]);
      end
    end

    // R7: modem control 0x1C sets bits 2 and 3
    chk("R7 out1N with bit2 set", out1N, 0);
    chk("R7 out2N with bit3 set", out2N, 0);
    busWrite(3'd4, 8'h08, 1'b0);
    chk("R7 out1N with bit2 clear", out1N, 1);
    chk("R7 out2N with bit3 set", out2N, 0);

    // R6: driver disable low during an addressed read, both forms
    busRead(3'd4, 1'b1, v, dd);
    chk("R6 drvDisableN read high form", dd, 0);
    busRead(3'd4, 1'b0, v, dd);
    chk("R6 drvDisableN read low form", dd, 0);

    // R8: divisor 4 from the walk
    countTicks(8, 40, n);
    chk("R8 ticks divisor 4", n, 10);
    busWrite(3'd3, 8'h80, 1'b1);
    busWrite(3'd0, 8'h01, 1'b1);
    countTicks(4, 16, n);
    chk("R8 ticks divisor 1", n, 16);
    busWrite(3'd0, 8'h03, 1'b0);
    countTicks(6, 30, n);
    chk("R8 ticks divisor 3", n, 10);
    busWrite(3'd0, 8'h00, 1'b1);
    countTicks(3, 50, n);
    chk("R9 ticks divisor 0", n, 0);
    busWrite(3'd1, 8'h01, 1'b1);
    busRead(3'd1, 1'b0, v, dd);
    chk("R4 divisor high byte", v, 8'h01);
    busWrite(3'd1, 8'h00, 1'b1);
    busWrite(3'd3, 8'h03, 1'b1);

    // R1: each chip select wrong in turn
    for (int k = 0; k < 3; k++) begin
      selHiA = (k != 0); selHiB = (k != 1); selLoN = (k == 2);
      busWrite(3'd4, 8'h00, 1'b1);
      busRead(3'd3, 1'b1, v, dd);
      chk("R1 deselected read data", v, 0);
      chk("R1 deselected drvDisableN", dd, 1);
      selHiA = 1'b1; selHiB = 1'b1; selLoN = 1'b0;
      busRead(3'd4, 1'b0, v, dd);
      chk("R1 deselected write ignored", v, 8'h08);
    end

    // R3: strobe rises, live address and selects change, latched ones used
    @(negedge clk);
    addr = 3'd4;
    @(negedge clk);
    addrStrobeN = 1'b1; addr = 3'd2; selLoN = 1'b1;
    rdHi = 1'b1;
    #1;
    chk("R3 latched address read", dataOut, 8'h08);
    rdHi = 1'b0;
    busWrite(3'd0, 8'h0C, 1'b1);
    addrStrobeN = 1'b0; selLoN = 1'b0;
    busRead(3'd4, 1'b1, v, dd);
    chk("R3 write through latched address", v, 8'h0C);

    // R10: master reset mid-run
    @(negedge clk);
    rstMaster = 1'b1;
    repeat (2) @(negedge clk);
    rstMaster = 1'b0;
    busRead(3'd4, 1'b1, v, dd);
    chk("R10 modem control cleared", v, 0);
    busRead(3'd3, 1'b0, v, dd);
    chk("R10 line control cleared", v, 0);
    busRead(3'd0, 1'b1, v, dd);
    chk("R10 data cleared", v, 0);
    chk("R10 out1N after reset", out1N, 1);
    chk("R10 out2N after reset", out2N, 1);
    countTicks(2, 20, n);
    chk("R10 baud stopped after reset", n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule